// File: doc/BRIEF.md
# Privileged Instruction Trap Unit

This unit sits next to the decode/execute stage of a 64-bit core. It guards the instructions that only supervisor code may run. A decoded instruction arrives with a valid strobe, its address, a privileged flag, an operation selector and the source register value. If the machine state register shows the core is in user (problem) state and the instruction carries the privileged flag, the unit drops every normal effect of the instruction and takes a program interrupt.

Taking the interrupt has three effects. The first save register receives the return address. The second save register receives the pre-trap machine state with a cause bit forced on. The machine state itself drops to supervisor mode with external interrupts masked, and the next fetch address becomes the program interrupt vector. When no trap is taken, the unit carries out the state-related operations it owns: reading the machine state into a general register, writing it from a source register, and returning from an interrupt. The two translation-invalidate operations need no state change here, so they only advance the PC.

All outputs are combinational in the cycle of the valid strobe. The machine state register and both save registers are held inside the unit and change on the following clock edge. The current machine state is also brought out as a port.

Top module: `priv_trap_unit`

## Requirements
- R1: On reset the machine state register (msr_q) holds 0, so bit 14, the user-state flag, is clear.
- R2: A trap is taken when in_valid, in_priv and msr_q[14] are all 1. A privileged instruction in supervisor state does not trap, and neither does an unflagged instruction in user state; both execute normally.
- R3: A trapped instruction has none of its normal effects: rd_we is 0 and the new MSR value is derived from the old MSR, not from in_rs.
- R4: On a trap, srr0_we is 1 and srr0_wdata equals in_pc + 4.
- R5: On a trap, srr1_we is 1 and srr1_wdata equals the pre-trap MSR with bit 17 forced to 1.
- R6: On a trap, msr_wdata is the old MSR with bits 14 and 15 cleared, and next_pc is 0x700.
- R7: Operation code 1 (move from machine state), when not trapped, sets rd_we with rd_wdata equal to msr_q.
- R8: Operation code 2 (move to machine state), when not trapped, writes in_rs into the MSR, and msr_q shows it in the next cycle.
- R9: Operation code 5 (return from interrupt), when not trapped, copies bits 11..6 and 3..0 of the saved SRR1 into the same MSR positions, keeps all other MSR bits, and sets next_pc to the saved SRR0 with its two low bits cleared.
- R10: Operation codes 0, 3 and 4 (plain, local TLB invalidate, segment table invalidate-all), when not trapped, write no register and set next_pc to in_pc + 4.
- R11: While in_valid is 0, trap_taken and every write enable are 0, and msr_q keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Instruction valid strobe |
| in_pc | input | 64 | Address of the instruction |
| in_priv | input | 1 | Instruction is flagged privileged |
| in_op | input | 3 | Operation selector (0 plain, 1 move from MSR, 2 move to MSR, 3 local TLB invalidate, 4 segment invalidate-all, 5 return from interrupt) |
| in_rs | input | 64 | Source register value |
| trap_taken | output | 1 | Program interrupt taken this cycle |
| next_pc | output | 64 | Next fetch address |
| srr0_we | output | 1 | Return-address save register write |
| srr0_wdata | output | 64 | Return address written |
| srr1_we | output | 1 | State save register write |
| srr1_wdata | output | 64 | Saved state with cause |
| msr_we | output | 1 | Machine state register write |
| msr_wdata | output | 64 | New machine state value |
| rd_we | output | 1 | Destination register write |
| rd_wdata | output | 64 | Destination register data |
| msr_q | output | 64 | Current machine state register |

## Verification
The bench builds the unit with its default parameters: a 64-bit word, the user flag at bit 14, the interrupt enable at bit 15, the cause at bit 17, a 0x700 vector, 4-byte instructions, and return-restored fields at 11..6 and 3..0. With these values one bench model can exercise a full round trip. Supervisor code can write a user-state MSR, a trap can save an unaligned return address, and the return can restore only the listed fields while leaving the user flag cleared. The stimulus also covers the case where the cause bit is already clear in the MSR, so that forcing it on is visible in SRR1.

// File: rtl/priv_trap_pkg.sv
package priv_trap_pkg;
   localparam int unsigned OP_W = 3;

   typedef enum logic [OP_W-1:0] {
      OP_PLAIN  = 3'd0,
      OP_MFMSR  = 3'd1,
      OP_MTMSRD = 3'd2,
      OP_TLBIEL = 3'd3,
      OP_SLBIA  = 3'd4,
      OP_RFID   = 3'd5
   } ptu_op_e;
endpackage

// File: rtl/ptu_check.sv
// Privilege gate: decides whether the incoming instruction traps.
module ptu_check #(
   parameter int unsigned XLEN   = 64,
   parameter int unsigned PR_BIT = 14
) (
   input  logic            valid,
   input  logic            priv,
   input  logic [XLEN-1:0] msr,
   output logic            trap
);
   assign trap = valid & priv & msr[PR_BIT];
endmodule

// File: rtl/ptu_reg.sv
// Resettable state register with write enable.
module ptu_reg #(
   parameter int unsigned W   = 64,
   parameter logic [W-1:0] RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST;
      else if (we) q <= d;
   end
endmodule

// File: rtl/ptu_trap.sv
// Values written when a program interrupt is taken.
module ptu_trap #(
   parameter int unsigned XLEN        = 64,
   parameter int unsigned PR_BIT      = 14,
   parameter int unsigned EE_BIT      = 15,
   parameter int unsigned CAUSE_BIT   = 17,
   parameter int unsigned VECTOR      = 'h700,
   parameter int unsigned ILEN_BYTES  = 4
) (
   input  logic [XLEN-1:0] pc,
   input  logic [XLEN-1:0] msr,
   output logic [XLEN-1:0] ret_addr,
   output logic [XLEN-1:0] save_state,
   output logic [XLEN-1:0] new_msr,
   output logic [XLEN-1:0] vec_pc
);
   localparam logic [XLEN-1:0] CAUSE_MASK = XLEN'(1) << CAUSE_BIT;
   localparam logic [XLEN-1:0] DROP_MASK  = (XLEN'(1) << PR_BIT) | (XLEN'(1) << EE_BIT);

   assign ret_addr   = pc + XLEN'(ILEN_BYTES);
   assign save_state = msr | CAUSE_MASK;
   assign new_msr    = msr & ~DROP_MASK;
   assign vec_pc     = XLEN'(VECTOR);
endmodule

// File: rtl/ptu_exec.sv
// Normal (untrapped) effects of the state-related operations.
module ptu_exec
   import priv_trap_pkg::*;
#(
   parameter int unsigned XLEN        = 64,
   parameter int unsigned ILEN_BYTES  = 4,
   parameter int unsigned RET_LO_MSB  = 3,
   parameter int unsigned RET_HI_LSB  = 6,
   parameter int unsigned RET_HI_MSB  = 11
) (
   input  logic            go,
   input  logic [OP_W-1:0] op,
   input  logic [XLEN-1:0] pc,
   input  logic [XLEN-1:0] rs,
   input  logic [XLEN-1:0] msr,
   input  logic [XLEN-1:0] srr0,
   input  logic [XLEN-1:0] srr1,
   output logic            rd_we,
   output logic [XLEN-1:0] rd_wdata,
   output logic            msr_we,
   output logic [XLEN-1:0] msr_wdata,
   output logic [XLEN-1:0] next_pc
);
   localparam int unsigned ALIGN_BITS = (ILEN_BYTES > 1) ? $clog2(ILEN_BYTES) : 1;
   localparam logic [XLEN-1:0] ALIGN_MASK = ~((XLEN'(1) << ALIGN_BITS) - XLEN'(1));

   ptu_op_e               op_e;
   logic [XLEN-1:0]       ret_msr;
   logic [XLEN-1:0]       seq_pc;

   assign op_e   = ptu_op_e'(op);
   assign seq_pc = pc + XLEN'(ILEN_BYTES);

   for (genvar b = 0; b < XLEN; b++) begin : g_ret_bit
      localparam bit FROM_SAVE = (b <= RET_LO_MSB) ||
                                 ((b >= RET_HI_LSB) && (b <= RET_HI_MSB));
      if (FROM_SAVE) begin : g_take
         assign ret_msr[b] = srr1[b];
      end else begin : g_keep
         assign ret_msr[b] = msr[b];
      end
   end

   always_comb begin
      rd_we     = 1'b0;
      rd_wdata  = '0;
      msr_we    = 1'b0;
      msr_wdata = msr;
      next_pc   = seq_pc;
      if (go) begin
         case (op_e)
            OP_MFMSR: begin
               rd_we    = 1'b1;
               rd_wdata = msr;
            end
            OP_MTMSRD: begin
               msr_we    = 1'b1;
               msr_wdata = rs;
            end
            OP_RFID: begin
               msr_we    = 1'b1;
               msr_wdata = ret_msr;
               next_pc   = srr0 & ALIGN_MASK;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/priv_trap_unit.sv
module priv_trap_unit
   import priv_trap_pkg::*;
#(
   parameter int unsigned XLEN       = 64,
   parameter int unsigned PR_BIT     = 14,
   parameter int unsigned EE_BIT     = 15,
   parameter int unsigned CAUSE_BIT  = 17,
   parameter int unsigned VECTOR     = 'h700,
   parameter int unsigned ILEN_BYTES = 4,
   parameter int unsigned RET_LO_MSB = 3,
   parameter int unsigned RET_HI_LSB = 6,
   parameter int unsigned RET_HI_MSB = 11,
   parameter logic [XLEN-1:0] MSR_RST = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [XLEN-1:0] in_pc,
   input  logic            in_priv,
   input  logic [OP_W-1:0] in_op,
   input  logic [XLEN-1:0] in_rs,
   output logic            trap_taken,
   output logic [XLEN-1:0] next_pc,
   output logic            srr0_we,
   output logic [XLEN-1:0] srr0_wdata,
   output logic            srr1_we,
   output logic [XLEN-1:0] srr1_wdata,
   output logic            msr_we,
   output logic [XLEN-1:0] msr_wdata,
   output logic            rd_we,
   output logic [XLEN-1:0] rd_wdata,
   output logic [XLEN-1:0] msr_q
);
   if (PR_BIT >= XLEN || EE_BIT >= XLEN || CAUSE_BIT >= XLEN) begin : g_bad_bit
      $error("priv_trap_unit: state bit index outside the word");
   end
   if (RET_HI_MSB >= XLEN || RET_HI_LSB > RET_HI_MSB || RET_LO_MSB >= RET_HI_LSB) begin : g_bad_ret
      $error("priv_trap_unit: return-restored fields malformed");
   end
   if (ILEN_BYTES == 0 || (ILEN_BYTES & (ILEN_BYTES - 1)) != 0) begin : g_bad_ilen
      $error("priv_trap_unit: instruction length must be a power of two");
   end

   logic            trap;
   logic [XLEN-1:0] srr0_q, srr1_q;
   logic [XLEN-1:0] t_ret, t_save, t_msr, t_vec;
   logic            x_rd_we, x_msr_we;
   logic [XLEN-1:0] x_rd_d, x_msr_d, x_pc;

   ptu_check #(.XLEN(XLEN), .PR_BIT(PR_BIT)) i_check (
      .valid(in_valid), .priv(in_priv), .msr(msr_q), .trap(trap)
   );

   ptu_trap #(
      .XLEN(XLEN), .PR_BIT(PR_BIT), .EE_BIT(EE_BIT), .CAUSE_BIT(CAUSE_BIT),
      .VECTOR(VECTOR), .ILEN_BYTES(ILEN_BYTES)
   ) i_trap (
      .pc(in_pc), .msr(msr_q), .ret_addr(t_ret), .save_state(t_save),
      .new_msr(t_msr), .vec_pc(t_vec)
   );

   ptu_exec #(
      .XLEN(XLEN), .ILEN_BYTES(ILEN_BYTES), .RET_LO_MSB(RET_LO_MSB),
      .RET_HI_LSB(RET_HI_LSB), .RET_HI_MSB(RET_HI_MSB)
   ) i_exec (
      .go(in_valid & ~trap), .op(in_op), .pc(in_pc), .rs(in_rs), .msr(msr_q),
      .srr0(srr0_q), .srr1(srr1_q), .rd_we(x_rd_we), .rd_wdata(x_rd_d),
      .msr_we(x_msr_we), .msr_wdata(x_msr_d), .next_pc(x_pc)
   );

   assign trap_taken = trap;
   assign next_pc    = trap ? t_vec : x_pc;
   assign srr0_we    = trap;
   assign srr0_wdata = t_ret;
   assign srr1_we    = trap;
   assign srr1_wdata = t_save;
   assign msr_we     = trap | x_msr_we;
   assign msr_wdata  = trap ? t_msr : x_msr_d;
   assign rd_we      = x_rd_we;
   assign rd_wdata   = x_rd_d;

   ptu_reg #(.W(XLEN), .RST(MSR_RST)) i_msr (
      .clk(clk), .rst_n(rst_n), .we(msr_we), .d(msr_wdata), .q(msr_q)
   );
   ptu_reg #(.W(XLEN), .RST('0)) i_srr0 (
      .clk(clk), .rst_n(rst_n), .we(srr0_we), .d(srr0_wdata), .q(srr0_q)
   );
   ptu_reg #(.W(XLEN), .RST('0)) i_srr1 (
      .clk(clk), .rst_n(rst_n), .we(srr1_we), .d(srr1_wdata), .q(srr1_q)
   );
endmodule

// File: rtl/ptu_checker.sv
module ptu_checker #(
   parameter int unsigned XLEN       = 64,
   parameter int unsigned PR_BIT     = 14,
   parameter int unsigned EE_BIT     = 15,
   parameter int unsigned CAUSE_BIT  = 17,
   parameter int unsigned VECTOR     = 'h700,
   parameter int unsigned ILEN_BYTES = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic [XLEN-1:0] in_pc,
   input logic            in_priv,
   input logic [2:0]      in_op,
   input logic [XLEN-1:0] in_rs,
   input logic            trap_taken,
   input logic [XLEN-1:0] next_pc,
   input logic            srr0_we,
   input logic [XLEN-1:0] srr0_wdata,
   input logic            srr1_we,
   input logic [XLEN-1:0] srr1_wdata,
   input logic            msr_we,
   input logic [XLEN-1:0] msr_wdata,
   input logic            rd_we,
   input logic [XLEN-1:0] rd_wdata,
   input logic [XLEN-1:0] msr_q
);
   a_r2_user_priv_traps: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_priv && msr_q[PR_BIT] |-> trap_taken);
   a_r2_super_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
      !msr_q[PR_BIT] |-> !trap_taken);
   a_r3_no_rd_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
      trap_taken |-> !rd_we);
   a_r4_return_addr: assert property (@(posedge clk) disable iff (!rst_n)
      trap_taken |-> srr0_we && srr0_wdata == in_pc + XLEN'(ILEN_BYTES));
   a_r5_cause_bit: assert property (@(posedge clk) disable iff (!rst_n)
      trap_taken |-> srr1_we && srr1_wdata[CAUSE_BIT]);
   a_r6_vector_entry: assert property (@(posedge clk) disable iff (!rst_n)
      trap_taken |-> next_pc == XLEN'(VECTOR) && !msr_wdata[PR_BIT] && !msr_wdata[EE_BIT]);
   a_r7_read_state: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !trap_taken && in_op == 3'd1 |-> rd_we && rd_wdata == msr_q);
   a_r8_write_state: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !trap_taken && in_op == 3'd2 |-> msr_we && msr_wdata == in_rs);
   a_r8_commit: assert property (@(posedge clk) disable iff (!rst_n)
      msr_we |=> msr_q == $past(msr_wdata));
   a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> !(trap_taken || srr0_we || srr1_we || msr_we || rd_we));
   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !msr_we |=> $stable(msr_q));
endmodule

bind priv_trap_unit ptu_checker #(
   .XLEN(XLEN), .PR_BIT(PR_BIT), .EE_BIT(EE_BIT), .CAUSE_BIT(CAUSE_BIT),
   .VECTOR(VECTOR), .ILEN_BYTES(ILEN_BYTES)
) i_ptu_checker (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pc(in_pc), .in_priv(in_priv),
   .in_op(in_op), .in_rs(in_rs), .trap_taken(trap_taken), .next_pc(next_pc),
   .srr0_we(srr0_we), .srr0_wdata(srr0_wdata), .srr1_we(srr1_we),
   .srr1_wdata(srr1_wdata), .msr_we(msr_we), .msr_wdata(msr_wdata),
   .rd_we(rd_we), .rd_wdata(rd_wdata), .msr_q(msr_q)
);

// File: tb/test_priv_trap_unit.sv
module test_priv_trap_unit;
   localparam int PERIOD = 10;

   typedef struct {
      string       tag;
      logic        trap;
      logic [63:0] npc;
      logic        s0_we;
      logic [63:0] s0_d;
      logic        s1_we;
      logic [63:0] s1_d;
      logic        m_we;
      logic [63:0] m_d;
      logic        r_we;
      logic [63:0] r_d;
      logic [63:0] m_now;
   } exp_t;

   logic        clk = 0, rst_n = 0;
   logic        in_valid = 0, in_priv = 0;
   logic [63:0] in_pc = '0, in_rs = '0;
   logic [2:0]  in_op = '0;
   logic        trap_taken, srr0_we, srr1_we, msr_we, rd_we;
   logic [63:0] next_pc, srr0_wdata, srr1_wdata, msr_wdata, rd_wdata, msr_q;

   int total = 0, bad = 0;
   exp_t sb[$];
   logic [63:0] m_msr = '0, m_s0 = '0, m_s1 = '0;

   always #(PERIOD/2) clk = ~clk;

   priv_trap_unit i_priv_trap_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pc(in_pc), .in_priv(in_priv),
      .in_op(in_op), .in_rs(in_rs), .trap_taken(trap_taken), .next_pc(next_pc),
      .srr0_we(srr0_we), .srr0_wdata(srr0_wdata), .srr1_we(srr1_we),
      .srr1_wdata(srr1_wdata), .msr_we(msr_we), .msr_wdata(msr_wdata),
      .rd_we(rd_we), .rd_wdata(rd_wdata), .msr_q(msr_q)
   );

   task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic drive(bit v, bit pr, logic [2:0] op, logic [63:0] pc, logic [63:0] rs, string tag);
      exp_t e;
      @(posedge clk);
      #1;
      e.tag = tag; e.m_now = m_msr;
      e.trap = v && pr && m_msr[14];
      e.npc = pc + 64'd4;
      e.s0_we = 0; e.s1_we = 0; e.m_we = 0; e.r_we = 0;
      e.s0_d = '0; e.s1_d = '0; e.m_d = '0; e.r_d = '0;
      if (v && e.trap) begin
         e.s0_we = 1; e.s0_d = pc + 64'd4;
         e.s1_we = 1; e.s1_d = m_msr | (64'd1 << 17);
         e.m_we = 1;  e.m_d = m_msr & ~(64'd3 << 14);
         e.npc = 64'h700;
      end else if (v) begin
         case (op)
            3'd1: begin e.r_we = 1; e.r_d = m_msr; end
            3'd2: begin e.m_we = 1; e.m_d = rs; end
            3'd5: begin
               e.m_we = 1; e.m_d = (m_msr & ~64'hFCF) | (m_s1 & 64'hFCF);
               e.npc = m_s0 & ~64'd3;
            end
            default: ;
         endcase
      end
      sb.push_back(e);
      in_valid = v; in_priv = pr; in_op = op; in_pc = pc; in_rs = rs;
      if (e.s0_we) m_s0 = e.s0_d;
      if (e.s1_we) m_s1 = e.s1_d;
      if (e.m_we)  m_msr = e.m_d;
   endtask

   always @(negedge clk) begin
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         chk(msr_q == e.m_now, e.tag, "msr_q", msr_q, e.m_now);
         chk(trap_taken == e.trap, e.tag, "trap_taken", 64'(trap_taken), 64'(e.trap));
         chk(next_pc == e.npc, e.tag, "next_pc", next_pc, e.npc);
         chk(srr0_we == e.s0_we, e.tag, "srr0_we", 64'(srr0_we), 64'(e.s0_we));
         if (e.s0_we) chk(srr0_wdata == e.s0_d, e.tag, "srr0_wdata", srr0_wdata, e.s0_d);
         chk(srr1_we == e.s1_we, e.tag, "srr1_we", 64'(srr1_we), 64'(e.s1_we));
         if (e.s1_we) chk(srr1_wdata == e.s1_d, e.tag, "srr1_wdata", srr1_wdata, e.s1_d);
         chk(msr_we == e.m_we, e.tag, "msr_we", 64'(msr_we), 64'(e.m_we));
         if (e.m_we) chk(msr_wdata == e.m_d, e.tag, "msr_wdata", msr_wdata, e.m_d);
         chk(rd_we == e.r_we, e.tag, "rd_we", 64'(rd_we), 64'(e.r_we));
         if (e.r_we) chk(rd_wdata == e.r_d, e.tag, "rd_wdata", rd_wdata, e.r_d);
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      drive(0, 0, 3'd0, 64'h0, 64'h0, "R1");                 // reset state
      drive(1, 1, 3'd1, 64'h1000, 64'h0, "R7");              // supervisor read
      drive(1, 1, 3'd2, 64'h1004, 64'hC8A5, "R8");           // enter user, EE set
      drive(1, 1, 3'd1, 64'h2000, 64'h0, "R5");              // user read traps, cause forced
      drive(1, 1, 3'd3, 64'h2100, 64'h0, "R10");             // supervisor invalidate
      drive(1, 1, 3'd2, 64'h2104, 64'h4F3A, "R8");           // user again
      drive(1, 1, 3'd2, 64'h3002, 64'hFFFF_FFFF_FFFF_FFFF, "R3"); // trapped write ignored
      drive(1, 0, 3'd0, 64'h3100, 64'h0, "R10");             // plain op
      drive(1, 1, 3'd5, 64'h3200, 64'h0, "R9");              // return, unaligned save
      drive(1, 1, 3'd2, 64'h3004, 64'h4000, "R8");
      drive(1, 0, 3'd0, 64'h5000, 64'h0, "R2");              // unflagged in user
      drive(1, 0, 3'd1, 64'h5004, 64'h0, "R2");              // unflagged read in user
      drive(1, 1, 3'd4, 64'h5008, 64'h0, "R6");              // user invalidate traps
      drive(1, 1, 3'd2, 64'h700, 64'h4003, "R8");
      drive(1, 1, 3'd5, 64'h6000, 64'h0, "R2");              // user return traps
      drive(0, 1, 3'd2, 64'h6100, 64'h1234, "R11");          // idle, inputs ignored
      drive(0, 0, 3'd0, 64'h0, 64'h0, "R11");
      drive(1, 1, 3'd5, 64'h6200, 64'h0, "R9");              // return with cause in SRR1
      @(posedge clk);
      #1 in_valid = 0;
      repeat (3) @(posedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule